// File: doc/BRIEF.md
# Static memory bus controller

This block connects an internal request port to an external asynchronous static memory, or to a memory-mapped peripheral, over a demultiplexed address and data bus. A request carries a chip-select index, an address, write data, two byte enables and a read/write flag. The controller takes the request only while it is idle. It then drives the active-low chip selects, output enable, write enable and byte-lane strobes through five timed phases. When the access is over it returns a one-cycle completion pulse, and read data for a read.

Each chip select has its own timing word and its own 4-bit attribute nibble. Both are held in a small register file that can be written and read back. The attribute nibble sets four things for that chip select: whether the data bus is 16 or 8 bits wide, whether the address is given in bytes, whether the external wait input is honoured, and whether the two byte lanes are driven separately. The timing word sets the cycle count of each phase. Register offsets are byte offsets. The attribute word sits at 0x0, and the timing word of chip select n sits at 0x4 + 4·n.

Top module: `static_mem_ctrl`

## Requirements
- R1: After reset every chip select, output enable, write enable and byte strobe is high, the data drive enable is low, and the request port is ready. The attribute word reads 0. Every timing word reads 0xFF1F_FFFF, which gives the longest count in each phase.
- R2: Registers read back what was written. Timing bits 23:21 always read 0. Attribute bits above 4·NUM_CS always read 0. An access to an offset whose low two bits are not zero writes nothing and reads 0.
- R3: A timing word holds these fields: address setup in bits 31:28, CS setup in 27:24, access in 20:16, CS hold in 15:12, address hold in 11:8. An access runs through five phases in this order. Address setup lasts that many cycles, with chip select high. CS setup lasts that many cycles, with chip select low and no strobe. Access lasts that many cycles, with the strobe low. CS hold follows, then address hold with chip select high. The address stays stable from the start of the access to its end.
- R4: A phase whose count is zero is skipped. An access count of zero gives an access phase of one cycle.
- R5: A read asserts the output enable only, during the access phase. Data is sampled in the last access cycle. With the 8-bit bus (attribute bit 0 clear), bits 15:8 of the read data return 0.
- R6: A write asserts the write enable only, during the access phase. It drives the write data with the drive enable high while chip select is low.
- R7: When attribute bit 2 is set, a low wait input in the last access cycle extends the access phase until the wait input is sampled high. When bit 2 is clear, the wait input has no effect.
- R8: When the 16-bit bus (bit 0) and byte lanes (bit 3) are both set, the lower strobe follows enable bit 0 and the upper strobe follows enable bit 1. Otherwise both strobes follow the access strobe.
- R9: With the 16-bit bus set and byte addressing (bit 1) clear, the external address is the request address shifted right by one. In every other case it is the request address unchanged.
- R10: The completion pulse lasts exactly one cycle. It appears in the first cycle after the last phase, when the port is ready again. A request presented while the controller is busy is ignored.
- R11: Only the selected chip select ever goes low. The access uses that chip select's own timing word and attribute nibble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | REG_AW | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| req_valid_i | input | 1 | Access request |
| req_ready_o | output | 1 | Controller idle, request taken |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_cs_i | input | CS_W | Chip-select index |
| req_addr_i | input | ADDR_W | Request address |
| req_wdata_i | input | 16 | Write data |
| req_be_i | input | 2 | Byte enables, bit 0 lower lane |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | 16 | Read data of the last read |
| mem_addr_o | output | ADDR_W | External address |
| mem_cs_no | output | NUM_CS | Chip selects, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_lb_no | output | 1 | Lower byte strobe, active low |
| mem_ub_no | output | 1 | Upper byte strobe, active low |
| mem_dq_o | output | 16 | Write data to the bus |
| mem_dq_oe_o | output | 1 | Data bus drive enable |
| mem_dq_i | input | 16 | Read data from the bus |
| mem_wait_ni | input | 1 | External wait, active low |

## Verification
The bench builds the controller with NUM_CS = 2 and ADDR_W = 16. With two chip selects, the bench can show that the unselected select stays high. It can also show that each access picks up only its own bank's timing word and attribute nibble, and that the attribute register's unused upper bits read 0. The 16-bit address leaves room to check the halved address against the byte address. Timing words that mix zero and non-zero fields, together with the reset timing word, exercise phase skipping, the one-cycle minimum access, and the longest count in every phase.

// File: rtl/smc_pkg.sv
package smc_pkg;
  localparam int DQ_W = 16;
  localparam logic [31:0] TIM_IMPL = 32'hFF1F_FFFF;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0, PH_ASU = 3'd1, PH_CSU = 3'd2, PH_ACC = 3'd3, PH_CHD = 3'd4, PH_AHD = 3'd5
  } phase_e;

  typedef struct packed {
    logic [3:0] asu;
    logic [3:0] csu;
    logic [4:0] acc;
    logic [3:0] chd;
    logic [3:0] ahd;
  } tim_t;

  typedef struct packed {
    logic byte_en;
    logic wait_en;
    logic byte_addr;
    logic bus16;
  } attr_t;

  // first phase after p with a non-zero count; access always runs
  function automatic phase_e phase_after(phase_e p, tim_t t);
    phase_e n;
    case (p)
      PH_IDLE: n = (t.asu != 0) ? PH_ASU : (t.csu != 0) ? PH_CSU : PH_ACC;
      PH_ASU:  n = (t.csu != 0) ? PH_CSU : PH_ACC;
      PH_CSU:  n = PH_ACC;
      PH_ACC:  n = (t.chd != 0) ? PH_CHD : (t.ahd != 0) ? PH_AHD : PH_IDLE;
      PH_CHD:  n = (t.ahd != 0) ? PH_AHD : PH_IDLE;
      default: n = PH_IDLE;
    endcase
    return n;
  endfunction

  // remaining cycles after the first one of phase p
  function automatic logic [4:0] phase_len(phase_e p, tim_t t);
    logic [4:0] n;
    case (p)
      PH_ASU:  n = {1'b0, t.asu} - 5'd1;
      PH_CSU:  n = {1'b0, t.csu} - 5'd1;
      PH_ACC:  n = (t.acc == 5'd0) ? 5'd0 : t.acc - 5'd1;
      PH_CHD:  n = {1'b0, t.chd} - 5'd1;
      PH_AHD:  n = {1'b0, t.ahd} - 5'd1;
      default: n = 5'd0;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/smc_regs.sv
module smc_regs import smc_pkg::*; #(
  parameter int NUM_CS = 2,
  parameter int REG_AW = 4,
  localparam int WORD_W = REG_AW - 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic [REG_AW-1:0]        addr_i,
  input  logic [31:0]              wdata_i,
  output logic [31:0]              rdata_o,
  output attr_t [NUM_CS-1:0]       attr_o,
  output tim_t  [NUM_CS-1:0]       tim_o
);
  logic [WORD_W-1:0]   word;
  logic                aligned;
  logic [4*NUM_CS-1:0] attr_q;
  logic [31:0]         tim_q [NUM_CS];

  assign word    = addr_i[REG_AW-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                attr_q <= '0;
    else if (wr_i && aligned && word == '0)     attr_q <= wdata_i[4*NUM_CS-1:0];
  end

  for (genvar b = 0; b < NUM_CS; b++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        tim_q[b] <= TIM_IMPL;
      else if (wr_i && aligned && word == WORD_W'(b + 1))
        tim_q[b] <= wdata_i & TIM_IMPL;
    end
    assign attr_o[b] = attr_t'(attr_q[4*b +: 4]);
    assign tim_o[b]  = '{asu: tim_q[b][31:28], csu: tim_q[b][27:24], acc: tim_q[b][20:16],
                         chd: tim_q[b][15:12], ahd: tim_q[b][11:8]};
  end

  always_comb begin
    rdata_o = '0;
    if (aligned) begin
      if (word == '0) rdata_o[4*NUM_CS-1:0] = attr_q;
      for (int b = 0; b < NUM_CS; b++)
        if (word == WORD_W'(b + 1)) rdata_o = tim_q[b];
    end
  end

  AST_RSV_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (aligned && word != '0) |-> (rdata_o[23:21] == 3'b000)) else $error("rsv bits");  // R2
endmodule

// File: rtl/smc_seq.sv
module smc_seq import smc_pkg::*; (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  tim_t   tim_i,
  input  logic   wait_en_i,
  input  logic   wait_ni,
  output phase_e phase_q_o,
  output phase_e phase_d_o,
  output logic   capture_o,
  output logic   done_o
);
  phase_e     ph_q, ph_d;
  logic [4:0] cnt_q, cnt_d;
  tim_t       tim_q;
  logic       wait_en_q, done_q, stall, fin;

  assign stall = (ph_q == PH_ACC) && wait_en_q && !wait_ni;
  assign fin   = (ph_q != PH_IDLE) && (cnt_q == 5'd0) && !stall;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    if (ph_q == PH_IDLE) begin
      if (start_i) begin
        ph_d  = phase_after(PH_IDLE, tim_i);
        cnt_d = phase_len(ph_d, tim_i);
      end
    end else if (fin) begin
      ph_d  = phase_after(ph_q, tim_q);
      cnt_d = phase_len(ph_d, tim_q);
    end else if (cnt_q != 5'd0) begin
      cnt_d = cnt_q - 5'd1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q      <= PH_IDLE;
      cnt_q     <= '0;
      tim_q     <= '0;
      wait_en_q <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      done_q <= fin && (ph_d == PH_IDLE);
      if (start_i && ph_q == PH_IDLE) begin
        tim_q     <= tim_i;
        wait_en_q <= wait_en_i;
      end
    end
  end

  assign phase_q_o = ph_q;
  assign phase_d_o = ph_d;
  assign capture_o = fin && (ph_q == PH_ACC);
  assign done_o    = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q) else $error("done width");  // R10
  AST_WAIT_EXTENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall |=> (ph_q == PH_ACC)) else $error("wait ignored");  // R7
  AST_HOLD_AFTER_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_CHD) |-> ($past(ph_q) == PH_ACC || $past(ph_q) == PH_CHD)) else $error("order");  // R3
endmodule

// File: rtl/smc_pins.sv
module smc_pins import smc_pkg::*; #(
  parameter int NUM_CS = 2,
  parameter int ADDR_W = 16,
  parameter int CS_W   = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  phase_e            phase_d_i,
  input  logic [CS_W-1:0]   cs_i,
  input  logic              we_i,
  input  logic [1:0]        be_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DQ_W-1:0]   wdata_i,
  input  attr_t             attr_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [NUM_CS-1:0] mem_cs_no,
  output logic              mem_oe_no,
  output logic              mem_we_no,
  output logic              mem_lb_no,
  output logic              mem_ub_no,
  output logic [DQ_W-1:0]   mem_dq_o,
  output logic              mem_dq_oe_o
);
  logic busy, cs_act, stb, split;
  logic [ADDR_W-1:0] addr_fmt;

  assign busy     = (phase_d_i != PH_IDLE);
  assign cs_act   = (phase_d_i == PH_CSU) || (phase_d_i == PH_ACC) || (phase_d_i == PH_CHD);
  assign stb      = (phase_d_i == PH_ACC);
  assign split    = attr_i.bus16 && attr_i.byte_en;
  assign addr_fmt = (attr_i.bus16 && !attr_i.byte_addr) ? (addr_i >> 1) : addr_i;

  // outputs registered from next phase so pins are glitch-free
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_addr_o  <= '0;
      mem_oe_no   <= 1'b1;
      mem_we_no   <= 1'b1;
      mem_lb_no   <= 1'b1;
      mem_ub_no   <= 1'b1;
      mem_dq_o    <= '0;
      mem_dq_oe_o <= 1'b0;
    end else begin
      if (busy) begin
        mem_addr_o <= addr_fmt;
        mem_dq_o   <= wdata_i;
      end
      mem_oe_no   <= !(stb && !we_i);
      mem_we_no   <= !(stb && we_i);
      mem_lb_no   <= !(stb && (!split || be_i[0]));
      mem_ub_no   <= !(stb && (!split || be_i[1]));
      mem_dq_oe_o <= cs_act && we_i;
    end
  end

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem_cs_no[i] <= 1'b1;
      else         mem_cs_no[i] <= !(cs_act && cs_i == CS_W'(i));
    end
  end

  AST_ONE_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~mem_cs_no)) else $error("multi cs");  // R11
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!mem_oe_no && !mem_we_no)) else $error("oe and we");  // R5
  AST_STROBE_IN_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_oe_no || !mem_we_no) |-> !(&mem_cs_no)) else $error("strobe outside cs");  // R3
  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(&mem_cs_no) && !(&$past(mem_cs_no))) |-> $stable(mem_addr_o)) else $error("addr moved");  // R3
endmodule

// File: rtl/static_mem_ctrl.sv
module static_mem_ctrl import smc_pkg::*; #(
  parameter int NUM_CS = 2,
  parameter int ADDR_W = 16,
  localparam int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
  localparam int REG_AW = $clog2(4 * (NUM_CS + 1))
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [CS_W-1:0]   req_cs_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [15:0]       req_wdata_i,
  input  logic [1:0]        req_be_i,
  output logic              rsp_done_o,
  output logic [15:0]       rsp_rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [NUM_CS-1:0] mem_cs_no,
  output logic              mem_oe_no,
  output logic              mem_we_no,
  output logic              mem_lb_no,
  output logic              mem_ub_no,
  output logic [15:0]       mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [15:0]       mem_dq_i,
  input  logic              mem_wait_ni
);
  attr_t [NUM_CS-1:0] attr_arr;
  tim_t  [NUM_CS-1:0] tim_arr;
  phase_e ph_q, ph_d;
  logic   accept, capture;

  logic              we_q;
  logic [CS_W-1:0]   cs_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DQ_W-1:0]   wdata_q, rdata_q;
  logic [1:0]        be_q;
  attr_t             attr_q, attr_sel;

  logic              we_c;
  logic [CS_W-1:0]   cs_c;
  logic [ADDR_W-1:0] addr_c;
  logic [DQ_W-1:0]   wdata_c;
  logic [1:0]        be_c;
  attr_t             attr_c;

  smc_regs #(.NUM_CS(NUM_CS), .REG_AW(REG_AW)) u_regs (
    .clk_i, .rst_ni, .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .attr_o(attr_arr), .tim_o(tim_arr)
  );

  assign req_ready_o = (ph_q == PH_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign attr_sel    = attr_arr[req_cs_i];

  smc_seq u_seq (
    .clk_i, .rst_ni, .start_i(accept), .tim_i(tim_arr[req_cs_i]),
    .wait_en_i(attr_sel.wait_en), .wait_ni(mem_wait_ni),
    .phase_q_o(ph_q), .phase_d_o(ph_d), .capture_o(capture), .done_o(rsp_done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q <= 1'b0; cs_q <= '0; addr_q <= '0; wdata_q <= '0; be_q <= '0; attr_q <= '0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        we_q <= req_we_i; cs_q <= req_cs_i; addr_q <= req_addr_i;
        wdata_q <= req_wdata_i; be_q <= req_be_i; attr_q <= attr_sel;
      end
      if (capture) rdata_q <= attr_q.bus16 ? mem_dq_i : {8'h00, mem_dq_i[7:0]};
    end
  end

  // request fields for the phase being entered
  assign we_c    = accept ? req_we_i    : we_q;
  assign cs_c    = accept ? req_cs_i    : cs_q;
  assign addr_c  = accept ? req_addr_i  : addr_q;
  assign wdata_c = accept ? req_wdata_i : wdata_q;
  assign be_c    = accept ? req_be_i    : be_q;
  assign attr_c  = accept ? attr_sel    : attr_q;

  smc_pins #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W), .CS_W(CS_W)) u_pins (
    .clk_i, .rst_ni, .phase_d_i(ph_d), .cs_i(cs_c), .we_i(we_c), .be_i(be_c),
    .addr_i(addr_c), .wdata_i(wdata_c), .attr_i(attr_c),
    .mem_addr_o, .mem_cs_no, .mem_oe_no, .mem_we_no, .mem_lb_no, .mem_ub_no,
    .mem_dq_o, .mem_dq_oe_o
  );

  assign rsp_rdata_o = rdata_q;

  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_ready_o && req_valid_i) |=> $stable(cs_q)) else $error("busy accept");  // R10
endmodule

// File: tb/static_mem_ctrl_tb.sv
module static_mem_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CS = 2;
  localparam int ADDR_W = 16;

  typedef struct packed {
    logic        cs;
    logic        we;
    logic [15:0] addr;
    logic [15:0] wdata;
    logic [1:0]  be;
    logic [31:0] tim;
    logic [3:0]  attr;
    logic [3:0]  wt;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 16'h0124, 16'h0000, 2'b11, 32'h1203_1100, 4'b0001, 4'd0},
    '{1'b1, 1'b1, 16'h0040, 16'hBEEF, 2'b10, 32'h0001_0000, 4'b1001, 4'd0},
    '{1'b0, 1'b0, 16'h00F3, 16'h0000, 2'b11, 32'h0000_0000, 4'b0000, 4'd0},
    '{1'b1, 1'b0, 16'h0210, 16'h0000, 2'b11, 32'h0102_0000, 4'b0101, 4'd4},
    '{1'b0, 1'b1, 16'h0077, 16'hA55A, 2'b01, 32'h2110_0200, 4'b1000, 4'd0},
    '{1'b1, 1'b0, 16'h0125, 16'h0000, 2'b11, 32'h0001_3000, 4'b0011, 4'd0},
    '{1'b0, 1'b0, 16'h0300, 16'h0000, 2'b11, 32'h0003_0000, 4'b0101, 4'd0},
    '{1'b1, 1'b0, 16'h0302, 16'h0000, 2'b11, 32'h0002_0000, 4'b0001, 4'd3}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic req_valid = 1'b0, req_ready, req_we = 1'b0;
  logic [0:0] req_cs = '0;
  logic [15:0] req_addr = '0, req_wdata = '0, rsp_rdata;
  logic [1:0] req_be = '0;
  logic rsp_done;
  logic [15:0] mem_addr, mem_dq_o, mem_dq_i;
  logic [1:0] mem_cs_n;
  logic mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic mem_wait_n = 1'b1;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_dq_i = mem_oe_n ? 16'h0000 : {~mem_addr[7:0], mem_addr[7:0]};

  static_mem_ctrl #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .req_valid_i(req_valid),
    .req_ready_o(req_ready), .req_we_i(req_we), .req_cs_i(req_cs), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_be_i(req_be), .rsp_done_o(rsp_done), .rsp_rdata_o(rsp_rdata),
    .mem_addr_o(mem_addr), .mem_cs_no(mem_cs_n), .mem_oe_no(mem_oe_n), .mem_we_no(mem_we_n),
    .mem_lb_no(mem_lb_n), .mem_ub_no(mem_ub_n), .mem_dq_o(mem_dq_o), .mem_dq_oe_o(mem_dq_oe),
    .mem_dq_i(mem_dq_i), .mem_wait_ni(mem_wait_n)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic run(input vec_t v, input bit prog, input string tag);
    int asu, csu, acc, chd, ahd, total, k, wl;
    int first_cs, first_stb, cs_cnt, stb_cnt, oe_cnt, we_cnt, lb_cnt, ub_cnt;
    bit other_low, split, wr_oe;
    logic [15:0] exp_addr, addr_cs, wr_dq, exp_rd;
    string acc_tag;
    asu = int'(v.tim[31:28]); csu = int'(v.tim[27:24]); chd = int'(v.tim[15:12]);
    ahd = int'(v.tim[11:8]);
    acc = (v.tim[20:16] == 0) ? 1 : int'(v.tim[20:16]);
    if (v.attr[2] && int'(v.wt) + 1 > acc) acc = int'(v.wt) + 1;
    total = asu + csu + acc + chd + ahd;
    acc_tag = v.attr[2] ? "R7" : (v.tim[20:16] == 0 || v.tim[31:28] == 0) ? "R4" : "R3";
    split = v.attr[0] && v.attr[3];
    exp_addr = (v.attr[0] && !v.attr[1]) ? (v.addr >> 1) : v.addr;
    exp_rd = v.attr[0] ? {~exp_addr[7:0], exp_addr[7:0]} : {8'h00, exp_addr[7:0]};
    if (prog) begin
      reg_write(4'(4 + 4 * v.cs), v.tim);
      reg_write(4'd0, 32'(v.attr) << (4 * v.cs));
    end
    first_cs = -1; first_stb = -1; cs_cnt = 0; stb_cnt = 0; oe_cnt = 0; we_cnt = 0;
    lb_cnt = 0; ub_cnt = 0; other_low = 0; wr_oe = 0; wr_dq = '0; addr_cs = '0; wl = 0; k = 0;
    @(negedge clk);
    req_valid = 1'b1; req_cs = v.cs; req_we = v.we; req_addr = v.addr;
    req_wdata = v.wdata; req_be = v.be;
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready && k < 300) begin
      if (!mem_cs_n[v.cs]) begin
        if (first_cs < 0) begin first_cs = k; addr_cs = mem_addr; end
        cs_cnt++;
      end
      if (!mem_cs_n[!v.cs]) other_low = 1;
      if (!mem_oe_n || !mem_we_n) begin
        if (first_stb < 0) first_stb = k;
        stb_cnt++;
        if (!mem_oe_n) oe_cnt++;
        if (!mem_we_n) begin we_cnt++; wr_dq = mem_dq_o; wr_oe = mem_dq_oe; end
        if (!mem_lb_n) lb_cnt++;
        if (!mem_ub_n) ub_cnt++;
        mem_wait_n = !(wl < int'(v.wt));
        if (wl < int'(v.wt)) wl++;
      end else mem_wait_n = 1'b1;
      // R10: a request while busy must be ignored
      if (k == 0) begin req_valid = 1'b1; req_cs = !v.cs; req_we = 1'b0; end
      else req_valid = 1'b0;
      k++;
      @(negedge clk);
    end
    req_valid = 1'b0; mem_wait_n = 1'b1;
    check(k == total, {tag, " R3 total"}, 32'(k), 32'(total));
    check(rsp_done == 1'b1, {tag, " R10 done"}, 32'(rsp_done), 32'd1);
    check(first_cs == asu, {tag, " R3 addr setup"}, 32'(first_cs), 32'(asu));
    check(first_stb - first_cs == csu, {tag, " R3 cs setup"}, 32'(first_stb - first_cs), 32'(csu));
    check(stb_cnt == acc, {tag, " ", acc_tag, " access len"}, 32'(stb_cnt), 32'(acc));
    check(cs_cnt == csu + acc + chd, {tag, " R3 cs len"}, 32'(cs_cnt), 32'(csu + acc + chd));
    check(addr_cs == exp_addr, {tag, " R9 addr"}, 32'(addr_cs), 32'(exp_addr));
    check(!other_low, {tag, " R11 other cs"}, 32'(other_low), 32'd0);
    check(lb_cnt == ((!split || v.be[0]) ? acc : 0), {tag, " R8 lb"}, 32'(lb_cnt),
          32'((!split || v.be[0]) ? acc : 0));
    check(ub_cnt == ((!split || v.be[1]) ? acc : 0), {tag, " R8 ub"}, 32'(ub_cnt),
          32'((!split || v.be[1]) ? acc : 0));
    if (v.we) begin
      check(we_cnt == acc && oe_cnt == 0, {tag, " R6 we only"}, 32'(we_cnt), 32'(acc));
      check(wr_dq == v.wdata && wr_oe, {tag, " R6 wdata"}, {15'h0, wr_oe, wr_dq}, {16'h1, v.wdata});
    end else begin
      check(oe_cnt == acc && we_cnt == 0, {tag, " R5 oe only"}, 32'(oe_cnt), 32'(acc));
      check(rsp_rdata == exp_rd, {tag, " R5 rdata"}, 32'(rsp_rdata), 32'(exp_rd));
    end
    @(negedge clk);
    check(req_ready && !rsp_done && mem_cs_n == 2'b11, {tag, " R10 ignored/pulse"},
          {29'h0, req_ready, rsp_done, &mem_cs_n}, 32'h5);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=%h exp=%h", 32'd1, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(mem_cs_n == 2'b11 && mem_oe_n && mem_we_n && mem_lb_n && mem_ub_n && !mem_dq_oe,
          "R1 pins", {26'h0, mem_cs_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n},
          32'h3F);
    check(req_ready && !rsp_done, "R1 ready", {30'h0, req_ready, rsp_done}, 32'h2);
    reg_read(4'd0, d); check(d == 32'h0, "R1 attr reset", d, 32'h0);
    reg_read(4'd4, d); check(d == 32'hFF1F_FFFF, "R1 tim0 reset", d, 32'hFF1F_FFFF);
    reg_read(4'd8, d); check(d == 32'hFF1F_FFFF, "R1 tim1 reset", d, 32'hFF1F_FFFF);
    run('{1'b0, 1'b0, 16'h0010, 16'h0000, 2'b11, 32'hFF1F_FFFF, 4'b0000, 4'd0}, 1'b0, "R1 reset timing");
    // R2 register readback
    reg_write(4'd8, 32'hFFFF_FFFF);
    reg_read(4'd8, d); check(d == 32'hFF1F_FFFF, "R2 tim1 mask", d, 32'hFF1F_FFFF);
    reg_write(4'd4, 32'h1234_5678);
    reg_read(4'd4, d); check(d == 32'h1214_5678, "R2 tim0", d, 32'h1214_5678);
    reg_read(4'd8, d); check(d == 32'hFF1F_FFFF, "R2 tim1 kept", d, 32'hFF1F_FFFF);
    reg_write(4'd0, 32'hFFFF_FFFF);
    reg_read(4'd0, d); check(d == 32'h0000_00FF, "R2 attr", d, 32'h0000_00FF);
    reg_write(4'd5, 32'h0000_0000);
    reg_read(4'd4, d); check(d == 32'h1214_5678, "R2 unaligned write", d, 32'h1214_5678);
    reg_read(4'd6, d); check(d == 32'h0, "R2 unaligned read", d, 32'h0);
    for (int i = 0; i < NV; i++) run(VECS[i], 1'b1, $sformatf("vec%0d", i));
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule